// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single countdown timer channel behind a small register bus. Software loads one control word that holds a run flag, a repeat flag and a 29-bit terminal count. The channel then counts down by one on every cycle in which the timebase strobe is high. When the count has passed through zero it raises a level-sensitive, active-high interrupt line.

The terminal count follows an "n+1" rule: a programmed value N expires on the (N+1)-th strobe. In one-shot mode the channel then drops its own run flag and parks at zero. In repeat mode it reloads the programmed value on the expiring strobe and keeps counting with no gap. The interrupt stays pending until software writes a one to the clear bit of the second register. Reading that register returns the live count and the pending flag.

Top module: `intv_timer`

## Requirements
- R1: After reset the interrupt line is low, and both registers read as zero.
- R2: The control word at byte offset 0x0 holds the run flag in bit 31, the repeat flag in bit 30 and the terminal count in bits 28:0. Bit 29 is not stored. The word reads back as written, except that the run flag drops after a one-shot expiry.
- R3: When the channel is running with count N, the interrupt rises on the (N+1)-th strobe and not earlier. N = 0 fires on the first strobe.
- R4: The count changes only on cycles where the strobe is high and the channel is running. Byte offset 0x4 reads the live count in bits 28:0 and the pending flag in bit 30, with all other bits zero.
- R5: In one-shot mode (bit 30 clear), expiry clears the run flag and holds the count at zero. Later strobes neither reload the count nor raise the interrupt again.
- R6: In repeat mode (bit 30 set), the expiring strobe reloads the terminal count. The next expiry follows N+1 strobes later, and the run flag stays set.
- R7: The interrupt stays high until a write to offset 0x4 has bit 30 set. A write to 0x4 with bit 30 clear leaves it pending.
- R8: Writing all zeros to the control word stops the channel. Later strobes leave the count unchanged and raise no interrupt.
- R9: Writing the control word while the channel runs loads the new count at once, and counting restarts from it on the next strobe.
- R10: When an expiry and a clear write fall in the same cycle, the interrupt ends up pending.
- R11: The largest terminal count, 0x1FFFFFFF, is stored and read back intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe, one count per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when bus_rd is low |
| irq | output | 1 | Level-high interrupt |

## Verification
The properties that follow the count and the interrupt only fire in cycles with no bus write. This reflects the assumption that any write may legally reshape the count or the pending flag. The bench applies strobes, writes and reads as single-cycle pulses driven away from the clock edge. It combines a write with a strobe only in the one case where that overlap is the point under test, the expiry-versus-clear collision. Terminal counts in the stimulus stay small so that every expiry falls inside the run, and the largest count is only stored and read back.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned CNT_W   = 29;
    localparam int unsigned RUN_BIT = 31;
    localparam int unsigned REP_BIT = 30;
    localparam int unsigned ACK_BIT = 30;
    localparam int unsigned OFF_CTL = 0;
    localparam int unsigned OFF_STS = 4;

    typedef struct packed {
        logic             run;
        logic             rep;
        logic [CNT_W-1:0] term;
    } ctl_word_t;

    typedef struct packed {
        logic      ld_ctl;
        logic      ack;
        ctl_word_t ctl;
    } bus_cmd_t;

    function automatic ctl_word_t unpack_ctl(input logic [DATA_W-1:0] w);
        ctl_word_t c;
        c.run  = w[RUN_BIT];
        c.rep  = w[REP_BIT];
        c.term = w[CNT_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctl(input ctl_word_t c);
        logic [DATA_W-1:0] w;
        w            = '0;
        w[RUN_BIT]   = c.run;
        w[REP_BIT]   = c.rep;
        w[CNT_W-1:0] = c.term;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_sts(input logic pend,
                                                   input logic [CNT_W-1:0] cnt);
        logic [DATA_W-1:0] w;
        w            = '0;
        w[ACK_BIT]   = pend;
        w[CNT_W-1:0] = cnt;
        return w;
    endfunction

endpackage

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  ctl_word_t         cur_ctl,
    input  logic [CNT_W-1:0]  cur_cnt,
    input  logic              cur_pend,
    output bus_cmd_t          cmd,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFF_CTL);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFF_STS);

    always_comb begin
        cmd.ld_ctl = bus_wr && (bus_addr == A_CTL);
        cmd.ack    = bus_wr && (bus_addr == A_STS) && bus_wdata[ACK_BIT];
        cmd.ctl    = unpack_ctl(bus_wdata);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == A_CTL)
                bus_rdata = pack_ctl(cur_ctl);
            else if (bus_addr == A_STS)
                bus_rdata = pack_sts(cur_pend, cur_cnt);
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  bus_cmd_t         cmd,
    output ctl_word_t        ctl_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);

    logic at_zero;

    assign at_zero = (cnt_q == '0);
    // A control write in the same cycle takes precedence over the strobe.
    assign expire  = tick && ctl_q.run && at_zero && !cmd.ld_ctl;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            cnt_q <= '0;
        end else if (cmd.ld_ctl) begin
            ctl_q <= cmd.ctl;
            cnt_q <= cmd.ctl.term;
        end else if (tick && ctl_q.run) begin
            if (at_zero) begin
                if (ctl_q.rep)
                    cnt_q <= ctl_q.term;
                else
                    ctl_q.run <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic ack,
    output logic pend_q
);

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (expire)
            pend_q <= 1'b1;
        else if (ack)
            pend_q <= 1'b0;
    end

endmodule

// File: rtl/intv_timer.sv
module intv_timer
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    bus_cmd_t         cmd;
    ctl_word_t        ctl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;
    logic             pend_q;

    logic             run_en;
    logic             run_rep;
    logic [CNT_W-1:0] run_term;

    assign run_en   = ctl_q.run;
    assign run_rep  = ctl_q.rep;
    assign run_term = ctl_q.term;

    tmr_regif #(.ADDR_W(ADDR_W)) u_regif (
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cur_ctl   (ctl_q),
        .cur_cnt   (cnt_q),
        .cur_pend  (pend_q),
        .cmd       (cmd),
        .bus_rdata (bus_rdata)
    );

    tmr_counter u_counter (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .cmd    (cmd),
        .ctl_q  (ctl_q),
        .cnt_q  (cnt_q),
        .expire (expire)
    );

    tmr_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .expire (expire),
        .ack    (cmd.ack),
        .pend_q (pend_q)
    );

    assign irq = pend_q;

endmodule

// File: rtl/intv_timer_chk.sv
module intv_timer_chk #(
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              irq,
    input logic              run_en,
    input logic              run_rep,
    input logic [28:0]       run_term,
    input logic [28:0]       cnt
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!irq && !run_en && cnt == '0));

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !bus_wr) |=> irq);

    // R4
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !bus_wr) |=> $stable(cnt));

    // R3
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && run_en && cnt != '0 && !bus_wr) |=> (cnt == $past(cnt) - 29'd1));

    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && run_en && !run_rep && cnt == '0 && !bus_wr)
        |=> (!run_en && cnt == '0 && irq));

    // R6
    repeat_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && run_en && run_rep && cnt == '0 && !bus_wr)
        |=> (run_en && cnt == $past(run_term) && irq));

    // R8
    zero_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == '0 && bus_wdata == '0) |=> (!run_en && cnt == '0));

endmodule

bind intv_timer intv_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .run_en    (run_en),
    .run_rep   (run_rep),
    .run_term  (run_term),
    .cnt       (cnt_q)
);

// File: tb/intv_timer_test.sv
`timescale 1ns/1ps
module intv_timer_test;

    localparam int unsigned ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq;
    logic              probe = 1'b0;

    int checks = 0;
    int failures = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #2.5 clk = ~clk;

    intv_timer #(.ADDR_W(ADDR_W)) uut (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic drive(input logic tk, input logic wr, input logic rd, input logic pr,
                         input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        tick = tk; bus_wr = wr; bus_rd = rd; probe = pr;
        bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, '0, '0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) drive(1, 0, 0, 0, '0, '0);
    endtask

    task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        drive(0, 1, 0, 0, a, d);
    endtask

    task automatic exp_rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        drive(0, 0, 1, 1, a, '0);
    endtask

    task automatic exp_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        drive(0, 0, 0, 1, '0, '0);
    endtask

    // monitor: samples one time unit after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (probe) begin
                item_t it;
                logic [31:0] act;
                checks++;
                if (sb_q.size() == 0) begin
                    failures++;
                    $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
                end else begin
                    it = sb_q.pop_front();
                    act = it.is_irq ? {31'b0, irq} : bus_rdata;
                    if (act !== it.exp) begin
                        failures++;
                        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        exp_rd(3'd0, 32'h0000_0000, "R1 ctl after reset");
        exp_rd(3'd4, 32'h0000_0000, "R1 sts after reset");
        exp_irq(1'b0, "R1 irq after reset");

        // R2 / R11 layout, bit 29 dropped, max count
        wr_reg(3'd0, 32'h7FFF_FFFF);
        exp_rd(3'd0, 32'h5FFF_FFFF, "R2 ctl readback");
        exp_rd(3'd4, 32'h1FFF_FFFF, "R11 max count loaded");
        ticks(2);
        exp_rd(3'd4, 32'h1FFF_FFFF, "R4 no count while stopped");

        // R3 N=0 fires on first strobe; R7 clear semantics
        wr_reg(3'd0, 32'h8000_0000);
        exp_irq(1'b0, "R3 no irq before strobe");
        ticks(1);
        exp_irq(1'b1, "R3 N=0 fires on one strobe");
        wr_reg(3'd4, 32'hBFFF_FFFF);
        exp_irq(1'b1, "R7 clear without bit30 ignored");
        wr_reg(3'd4, 32'h4000_0000);
        exp_irq(1'b0, "R7 clear with bit30");

        // R3 / R5 one-shot N=3
        wr_reg(3'd0, 32'h8000_0003);
        ticks(3);
        exp_irq(1'b0, "R3 not yet after N strobes");
        ticks(1);
        exp_irq(1'b1, "R3 fires on N+1 strobe");
        exp_rd(3'd4, 32'h4000_0000, "R4 sts pending and zero");
        exp_rd(3'd0, 32'h0000_0003, "R5 run flag cleared");
        ticks(3);
        exp_rd(3'd4, 32'h4000_0000, "R5 count held at zero");
        wr_reg(3'd4, 32'h4000_0000);
        ticks(2);
        exp_irq(1'b0, "R5 no refire");

        // R4 counts only on strobes; R9 restart; R8 zero write
        wr_reg(3'd0, 32'h8000_0005);
        idle(4);
        exp_rd(3'd4, 32'h0000_0005, "R4 idle cycles no decrement");
        ticks(2);
        exp_rd(3'd4, 32'h0000_0003, "R4 decrement per strobe");
        wr_reg(3'd0, 32'h8000_0009);
        ticks(1);
        exp_rd(3'd4, 32'h0000_0008, "R9 restart from new value");
        wr_reg(3'd0, 32'h0000_0000);
        ticks(3);
        exp_irq(1'b0, "R8 stopped no irq");
        exp_rd(3'd0, 32'h0000_0000, "R8 ctl zero");
        exp_rd(3'd4, 32'h0000_0000, "R8 count held");

        // R6 repeat mode N=2
        wr_reg(3'd0, 32'hC000_0002);
        ticks(3);
        exp_irq(1'b1, "R6 first expiry");
        exp_rd(3'd4, 32'h4000_0002, "R6 reload on expiry");
        wr_reg(3'd4, 32'h4000_0000);
        ticks(2);
        exp_rd(3'd4, 32'h0000_0000, "R6 counting again");
        exp_irq(1'b0, "R6 no early second fire");
        ticks(1);
        exp_irq(1'b1, "R6 second expiry");
        exp_rd(3'd0, 32'hC000_0002, "R6 run flag kept");

        // R10 expiry and clear in the same cycle
        wr_reg(3'd4, 32'h4000_0000);
        ticks(2);
        drive(1, 1, 0, 0, 3'd4, 32'h4000_0000);
        exp_irq(1'b1, "R10 expiry wins over clear");
        exp_rd(3'd4, 32'h4000_0002, "R10 reload with clear");
        wr_reg(3'd4, 32'h4000_0000);
        exp_irq(1'b0, "R10 later clear works");
        wr_reg(3'd0, 32'h0000_0000);

        idle(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule